// File: doc/BRIEF.md
# Settable 12-Hour Clock with Seven-Segment Digits

This block keeps the time of day as hours and minutes in 12-hour form and shows it on four seven-segment digit outputs. It runs from one system clock: a divider turns that clock into a one-second tick, and a binary-coded-decimal counter chain counts seconds (not shown), minutes and hours. The hours go 12, 1, 2, and so on up to 11, then back to 12. The tens digit of the hour shows 0 for the hours 1 to 9.

The time is set with three push-buttons. Holding the set button freezes normal timekeeping. While it is held, each fresh press of the hour button adds one hour and each fresh press of the minute button adds one minute. Each button is synchronized and edge-detected, so one press counts exactly once. A button that is already down when set mode starts does not count. Minute steps wrap from 59 to 00 without touching the hours. A minute step also clears the seconds and the sub-second divider, so the next full minute starts from the release of the set button. An active-low reset returns the time to 12:00.

The block has no streamed data. All pins are plain level signals.

Top module: `hm_clock12`

## Requirements
- R1: While `rst_n` is low, and after it goes high, the time reads 12:00 with seconds and the sub-second divider at zero.
- R2: Outside set mode, a one-second tick occurs once every `TICKS_PER_SEC` clock cycles (24,000,000 by default). The minutes advance on exactly one tick in every 60.
- R3: The minute units count 0 to 9 and carry into the minute tens, which count 0 to 5. The step from :59 to :00 carries one hour.
- R4: Timekeeping steps the hour from 12 to 01, from 09 to 10, and from 11 to 12. The hour stays within 1..12.
- R5: While `btn_set` is held (synchronized high), the seconds, minutes and hours change only through button steps.
- R6: In set mode, each rising edge of `btn_hour` adds exactly one hour, with 12 stepping to 01.
- R7: In set mode, each rising edge of `btn_min` adds exactly one minute. The minutes wrap from 59 to 00 and the hours do not change.
- R8: A minute step clears the seconds and the sub-second divider. After the set button is released, the next minute roll comes 60 ticks later.
- R9: Presses of `btn_hour` or `btn_min` while set mode is off have no effect. A button already held when set mode starts does not count until it is released and pressed again.
- R10: Each segment output is active-low, with bit 0 = segment a through bit 6 = segment g. The digits 0..9 light the usual seven-segment shapes, for example 0 = 7'b1000000, 1 = 7'b1111001 and 8 = 7'b0000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (24 MHz by default) |
| rst_n | input | 1 | Asynchronous active-low reset to 12:00 |
| btn_set | input | 1 | Set-mode enable, held high while setting |
| btn_hour | input | 1 | Hour step button, high when pressed |
| btn_min | input | 1 | Minute step button, high when pressed |
| seg_hr_hi | output | 7 | Hour tens digit, active-low segments g..a |
| seg_hr_lo | output | 7 | Hour units digit, active-low segments g..a |
| seg_mn_hi | output | 7 | Minute tens digit, active-low segments g..a |
| seg_mn_lo | output | 7 | Minute units digit, active-low segments g..a |

## Verification
The assertions take the button inputs to be clean levels that change at most once every few cycles. They also take a press to be held longer than the two-stage synchronizer, so that each press gives exactly one edge, and the set button to stay steady while a press is made. The stimulus holds every press for three cycles and leaves three cycles between presses. It raises the set button four cycles before the first press and drops it four cycles after the last. Timekeeping is checked over windows of exactly 60 ticks, so the expected minute count does not depend on the tick phase.

// File: rtl/hm_clock12_pkg.sv
package hm_clock12_pkg;

  typedef struct packed {
    logic [3:0] hr_hi;
    logic [3:0] hr_lo;
    logic [3:0] mn_hi;
    logic [3:0] mn_lo;
  } hm_time_t;

  localparam hm_time_t TIME_AT_RESET = '{hr_hi: 4'd1, hr_lo: 4'd2, mn_hi: 4'd0, mn_lo: 4'd0};

  // Next minute pair {tens, units}; wraps 59 -> 00
  function automatic logic [7:0] minute_next(input logic [3:0] hi, input logic [3:0] lo);
    if (lo == 4'd9) begin
      if (hi == 4'd5) return 8'h00;
      return {hi + 4'd1, 4'd0};
    end
    return {hi, lo + 4'd1};
  endfunction

  // Next hour pair {tens, units} in 12-hour form
  function automatic logic [7:0] hour_next(input logic [3:0] hi, input logic [3:0] lo);
    if (hi == 4'd1 && lo == 4'd2) return {4'd0, 4'd1};
    if (lo == 4'd9) return {4'd1, 4'd0};
    return {hi, lo + 4'd1};
  endfunction

endpackage

// File: rtl/hm_tick_gen.sv
module hm_tick_gen #(
  parameter int TICKS_PER_SEC = 24_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic tick
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign tick = en & ~clr & (cnt == LAST);
endmodule

// File: rtl/hm_btn_sync.sv
module hm_btn_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] btn_in,
  output logic [N-1:0] level,
  output logic [N-1:0] rise
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1, s2, prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1   <= 1'b0;
        s2   <= 1'b0;
        prev <= 1'b0;
      end else begin
        s1   <= btn_in[g];
        s2   <= s1;
        prev <= s2;
      end
    end
    assign level[g] = s2;
    assign rise[g]  = s2 & ~prev;
  end
endmodule

// File: rtl/hm_time_core.sv
module hm_time_core
  import hm_clock12_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     hr_step,
  input  logic     min_step,
  output hm_time_t now
);
  logic [5:0] sec, sec_nxt;
  hm_time_t   now_nxt;

  always_comb begin
    now_nxt = now;
    sec_nxt = sec;
    if (min_step || hr_step) begin
      if (min_step) begin
        {now_nxt.mn_hi, now_nxt.mn_lo} = minute_next(now.mn_hi, now.mn_lo);
        sec_nxt = '0;
      end
      if (hr_step) begin
        {now_nxt.hr_hi, now_nxt.hr_lo} = hour_next(now.hr_hi, now.hr_lo);
      end
    end else if (tick) begin
      if (sec == 6'd59) begin
        sec_nxt = '0;
        {now_nxt.mn_hi, now_nxt.mn_lo} = minute_next(now.mn_hi, now.mn_lo);
        if (now.mn_hi == 4'd5 && now.mn_lo == 4'd9) begin
          {now_nxt.hr_hi, now_nxt.hr_lo} = hour_next(now.hr_hi, now.hr_lo);
        end
      end else begin
        sec_nxt = sec + 6'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec <= '0;
      now <= TIME_AT_RESET;
    end else begin
      sec <= sec_nxt;
      now <= now_nxt;
    end
  end
endmodule

// File: rtl/hm_seg_dec.sv
module hm_seg_dec (
  input  logic [3:0] digit,
  output logic [6:0] seg_n
);
  always_comb begin
    unique case (digit)
      4'd0:    seg_n = 7'b1000000;
      4'd1:    seg_n = 7'b1111001;
      4'd2:    seg_n = 7'b0100100;
      4'd3:    seg_n = 7'b0110000;
      4'd4:    seg_n = 7'b0011001;
      4'd5:    seg_n = 7'b0010010;
      4'd6:    seg_n = 7'b0000010;
      4'd7:    seg_n = 7'b1111000;
      4'd8:    seg_n = 7'b0000000;
      4'd9:    seg_n = 7'b0010000;
      default: seg_n = 7'b1111111;
    endcase
  end
endmodule

// File: rtl/hm_clock12.sv
module hm_clock12
  import hm_clock12_pkg::*;
#(
  parameter int TICKS_PER_SEC = 24_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_set,
  input  logic       btn_hour,
  input  logic       btn_min,
  output logic [6:0] seg_hr_hi,
  output logic [6:0] seg_hr_lo,
  output logic [6:0] seg_mn_hi,
  output logic [6:0] seg_mn_lo
);
  localparam int NBTN = 3;
  localparam int NDIG = 4;

  logic [NBTN-1:0] btn_lvl, btn_rise;
  logic            set_on, hr_step, min_step, tick;
  hm_time_t        now;
  logic [3:0]      digits [NDIG];
  logic [6:0]      segs   [NDIG];

  hm_btn_sync #(.N(NBTN)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .btn_in ({btn_min, btn_hour, btn_set}),
    .level  (btn_lvl),
    .rise   (btn_rise)
  );

  assign set_on   = btn_lvl[0];
  assign hr_step  = set_on & btn_rise[1];
  assign min_step = set_on & btn_rise[2];

  hm_tick_gen #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (~set_on),
    .clr   (min_step),
    .tick  (tick)
  );

  hm_time_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .hr_step  (hr_step),
    .min_step (min_step),
    .now      (now)
  );

  assign digits[0] = now.mn_lo;
  assign digits[1] = now.mn_hi;
  assign digits[2] = now.hr_lo;
  assign digits[3] = now.hr_hi;

  for (genvar g = 0; g < NDIG; g++) begin : g_dec
    hm_seg_dec u_dec (.digit(digits[g]), .seg_n(segs[g]));
  end

  assign seg_mn_lo = segs[0];
  assign seg_mn_hi = segs[1];
  assign seg_hr_lo = segs[2];
  assign seg_hr_hi = segs[3];
endmodule

// File: rtl/hm_clock12_chk.sv
module hm_clock12_chk
  import hm_clock12_pkg::*;
#(
  parameter int TICKS_PER_SEC = 24_000_000
) (
  input logic     clk,
  input logic     rst_n,
  input logic     tick,
  input logic     set_on,
  input logic     hr_step,
  input logic     min_step,
  input hm_time_t now
);
  AST_MIN_LO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    now.mn_lo <= 4'd9); // R3
  AST_MIN_HI_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    now.mn_hi <= 4'd5); // R3
  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (now.hr_hi == 4'd0 && now.hr_lo != 4'd0) || (now.hr_hi == 4'd1 && now.hr_lo <= 4'd2)); // R4
  AST_SET_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    set_on && !hr_step && !min_step |=> $stable(now)); // R5
  AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    hr_step && now.hr_hi == 4'd1 && now.hr_lo == 4'd2 |=> now.hr_hi == 4'd0 && now.hr_lo == 4'd1); // R6
  AST_MIN_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    min_step && !hr_step && now.mn_hi == 4'd5 && now.mn_lo == 4'd9
      |=> now.mn_hi == 4'd0 && now.mn_lo == 4'd0 && $stable(now.hr_lo) && $stable(now.hr_hi)); // R7
  AST_STEP_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hr_step || min_step |-> set_on); // R9

  if (TICKS_PER_SEC > 1) begin : g_tick_gap
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R2
  end
endmodule

bind hm_clock12 hm_clock12_chk #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .set_on   (set_on),
  .hr_step  (hr_step),
  .min_step (min_step),
  .now      (now)
);

// File: tb/test_hm_clock12.sv
module test_hm_clock12;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_N     = 4;
  localparam int MINUTE     = 60 * TICK_N;
  localparam int WATCHDOG   = 100_000;
  localparam logic [1:0] OP_HOUR = 2'd0, OP_MIN = 2'd1, OP_RUN = 2'd2;
  localparam int NVEC = 16;

  // {op, count, expected hhmm as BCD}
  localparam logic [25:0] VEC [NVEC] = '{
    {OP_HOUR, 8'd1,  16'h0100},
    {OP_HOUR, 8'd8,  16'h0900},
    {OP_HOUR, 8'd1,  16'h1000},
    {OP_HOUR, 8'd2,  16'h1200},
    {OP_MIN,  8'd59, 16'h1259},
    {OP_MIN,  8'd1,  16'h1200},
    {OP_MIN,  8'd59, 16'h1259},
    {OP_RUN,  8'd1,  16'h0100},
    {OP_HOUR, 8'd8,  16'h0900},
    {OP_MIN,  8'd58, 16'h0958},
    {OP_RUN,  8'd1,  16'h0959},
    {OP_RUN,  8'd1,  16'h1000},
    {OP_RUN,  8'd2,  16'h1002},
    {OP_HOUR, 8'd1,  16'h1102},
    {OP_MIN,  8'd57, 16'h1159},
    {OP_RUN,  8'd1,  16'h1200}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_set = 1'b0, btn_hour = 1'b0, btn_min = 1'b0;
  logic [6:0] seg_hr_hi, seg_hr_lo, seg_mn_hi, seg_mn_lo;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hm_clock12 #(.TICKS_PER_SEC(TICK_N)) i_hm_clock12 (
    .clk(clk), .rst_n(rst_n), .btn_set(btn_set), .btn_hour(btn_hour), .btn_min(btn_min),
    .seg_hr_hi(seg_hr_hi), .seg_hr_lo(seg_hr_lo), .seg_mn_hi(seg_mn_hi), .seg_mn_lo(seg_mn_lo)
  );

  // Active-high lit segments (g..a), inverted for the active-low pins
  function automatic logic [6:0] shape(input logic [3:0] d);
    logic [6:0] lit;
    case (d)
      4'd0: lit = 7'h3F; 4'd1: lit = 7'h06; 4'd2: lit = 7'h5B; 4'd3: lit = 7'h4F;
      4'd4: lit = 7'h66; 4'd5: lit = 7'h6D; 4'd6: lit = 7'h7D; 4'd7: lit = 7'h07;
      4'd8: lit = 7'h7F; 4'd9: lit = 7'h6F; default: lit = 7'h00;
    endcase
    return ~lit;
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_time(input string req, input logic [15:0] hhmm);
    logic [27:0] got, exp;
    got = {seg_hr_hi, seg_hr_lo, seg_mn_hi, seg_mn_lo};
    exp = {shape(hhmm[15:12]), shape(hhmm[11:8]), shape(hhmm[7:4]), shape(hhmm[3:0])};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: segments %h, expected %h (time %h)", req, got, exp, hhmm);
    end
  endtask

  task automatic presses(input bit hour, input int n);
    btn_set = 1'b1;
    cycles(4);
    for (int i = 0; i < n; i++) begin
      if (hour) btn_hour = 1'b1; else btn_min = 1'b1;
      cycles(3);
      btn_hour = 1'b0;
      btn_min  = 1'b0;
      cycles(3);
    end
    cycles(4);
    btn_set = 1'b0;
    cycles(4);
  endtask

  initial begin
    cycles(3);
    check_time("R1 in reset", 16'h1200);
    rst_n = 1'b1;
    cycles(1);
    check_time("R1 after reset", 16'h1200);
    // R10 digit shapes are covered by every check via shape()
    for (int v = 0; v < NVEC; v++) begin
      case (VEC[v][25:24])
        OP_HOUR: presses(1'b1, int'(VEC[v][23:16]));              // R4 R6
        OP_MIN:  presses(1'b0, int'(VEC[v][23:16]));              // R7
        default: cycles(MINUTE * int'(VEC[v][23:16]));            // R2 R3 R4
      endcase
      check_time($sformatf("R3 R4 R6 R7 R10 vector %0d", v), VEC[v][15:0]);
    end

    // R1: reset while running, then exact first minute boundary (R2)
    rst_n = 1'b0;
    cycles(2);
    check_time("R1 reset mid-run", 16'h1200);
    rst_n = 1'b1;
    cycles(59 * TICK_N);
    check_time("R2 59 ticks no roll", 16'h1200);
    cycles(6);
    check_time("R2 60th tick rolls", 16'h1201);

    // R8: seconds cleared by a minute step
    cycles(30 * TICK_N);
    presses(1'b0, 1);
    check_time("R8 step", 16'h1202);
    cycles(59 * TICK_N - 8);
    check_time("R8 seconds restarted", 16'h1202);
    cycles(20);
    check_time("R8 next roll", 16'h1203);

    // R5: set mode freezes timekeeping
    btn_set = 1'b1;
    cycles(3 * MINUTE);
    check_time("R5 frozen", 16'h1203);
    btn_set = 1'b0;
    cycles(4);

    // R9: button held before set, and presses outside set mode
    btn_hour = 1'b1;
    cycles(5);
    btn_set = 1'b1;
    cycles(6);
    check_time("R9 held hour ignored", 16'h1203);
    btn_hour = 1'b0;
    cycles(3);
    btn_set = 1'b0;
    cycles(4);
    btn_min = 1'b1;
    cycles(3);
    btn_min = 1'b0;
    cycles(3);
    btn_hour = 1'b1;
    cycles(3);
    btn_hour = 1'b0;
    cycles(3);
    check_time("R9 press outside set", 16'h1203);

    // R6: hour press in set mode after the hold case
    presses(1'b1, 1);
    check_time("R6 single step", 16'h0103);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule